// File: doc/BRIEF.md
# Receive Flow-Control Character Detector

This block sits between a UART receiver and its receive FIFO. Every character the receiver delivers is compared with two programmable values: a resume (Xon) character and a stop (Xoff) character. The block decides whether the character is written into the FIFO. It drives a gate that pauses or releases the channel transmitter. It also records a recognition event that can raise a maskable interrupt.

The comparators run at all times, so they also work as general-purpose character detectors when flow control is off. When automatic gating is enabled, received stop and resume characters control the gate. In host mode, only the host's stop and resume commands control it. A software reset always releases the gate.

A character that arrives while the FIFO is full is an overrun. It is dropped, and it has no effect on the gate or on the status. A transparency control keeps matched characters out of the FIFO. The gate only tells the transmitter whether it may start its next character. The transmitter samples the gate between characters, so a character already in progress always finishes.

Top module: `rx_flow_detect`

## Requirements
- R1: After reset, `tx_enable` is 1 and `fifo_push`, `match_stat` and `irq` are 0.
- R2: An accepted character (`rx_valid`=1 and `fifo_full`=0) that matches neither reference is written one cycle later. `fifo_push` is then 1 for one cycle, and `fifo_data`/`fifo_err` carry the character and its error bits.
- R3: With `transparent`=0, a matched character is written with its own error bits, exactly like any other character. Error bits never stop a match.
- R4: With `transparent`=1, an accepted character equal to `xon_char` or `xoff_char` is not written. Non-matching characters are still written.
- R5: While `fifo_full`=1, a received character is not written and leaves `tx_enable` and `match_stat` unchanged.
- R6: With `auto_gate_en`=1, an accepted match of `xoff_char` drives `tx_enable` to 0 on the next cycle. An accepted match of `xon_char` drives it to 1. If both references hold the same value, the stop wins.
- R7: A zero character, such as one inserted by break detection (error bit 2 set), is matched like any other value.
- R8: With `auto_gate_en`=1, `host_stop` and `host_resume` have no effect. With `auto_gate_en`=0, received characters do not move the gate. In that mode `host_stop` clears `tx_enable` and `host_resume` sets it on the next cycle, and stop wins if both are asserted together.
- R9: `sw_reset` sets `tx_enable` to 1 on the next cycle in every mode, overriding any stop in the same cycle.
- R10: An accepted match sets `match_stat` on the next cycle in any mode. It stays set until a `stat_clr` pulse clears it, and a new match in the same cycle as a clear wins. `irq` equals `match_stat` AND `irq_mask`.
- R11: Gate changes caused by commands, resets or stop/resume characters do not set `match_stat` on their own. Non-matching characters do not set it either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Received character strobe |
| rx_char | input | DATA_W | Received character |
| rx_err | input | ERR_W | Error bits of the character (bit 2 = break) |
| fifo_full | input | 1 | Receive FIFO has no room |
| xon_char | input | DATA_W | Resume character reference |
| xoff_char | input | DATA_W | Stop character reference |
| auto_gate_en | input | 1 | Received characters control the transmitter gate |
| transparent | input | 1 | Keep matched characters out of the FIFO |
| host_stop | input | 1 | Host command: pause transmitter |
| host_resume | input | 1 | Host command: release transmitter |
| sw_reset | input | 1 | Software reset: release transmitter |
| irq_mask | input | 1 | Interrupt enable for recognition events |
| stat_clr | input | 1 | Write-one-to-clear strobe for the status |
| fifo_push | output | 1 | FIFO write strobe |
| fifo_data | output | DATA_W | Character written to the FIFO |
| fifo_err | output | ERR_W | Error bits written to the FIFO |
| tx_enable | output | 1 | Transmitter may start its next character |
| match_stat | output | 1 | Recognition status |
| irq | output | 1 | Masked recognition interrupt |

## Verification
The detector is driven with plain characters, with stop and resume characters that carry error bits, and with a zero character flagged as break. This separates the cases where a character is stored from those where it moves the gate. The same characters are repeated with transparency on, with the FIFO full and in host mode. That shows which of the three controls suppresses the write, the gate change or the status. Host commands are applied during automatic gating and together with received characters or a software reset, which exposes the priority order. Finally both references are set to the same value, which checks that stop wins over resume.

// File: rtl/rxfd_pkg.sv
package rxfd_pkg;
  localparam int unsigned FC_REFS = 2;
  localparam int unsigned FC_ON   = 0;
  localparam int unsigned FC_OFF  = 1;

  typedef struct packed {
    logic hit_on;
    logic hit_off;
  } fc_hit_t;

  typedef enum logic [1:0] {
    GATE_HOLD = 2'd0,
    GATE_STOP = 2'd1,
    GATE_RUN  = 2'd2
  } gate_req_e;
endpackage

// File: rtl/rxfd_match.sv
module rxfd_match
  import rxfd_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] chr,
  input  logic [DATA_W-1:0] xon_ref,
  input  logic [DATA_W-1:0] xoff_ref,
  output fc_hit_t           hit
);
  logic [FC_REFS-1:0][DATA_W-1:0] refs;
  logic [FC_REFS-1:0]             eq;

  assign refs[FC_ON]  = xon_ref;
  assign refs[FC_OFF] = xoff_ref;

  // one equality comparator per reference, always active
  for (genvar k = 0; k < FC_REFS; k++) begin : g_cmp
    assign eq[k] = (chr == refs[k]);
  end

  assign hit.hit_on  = eq[FC_ON];
  assign hit.hit_off = eq[FC_OFF];
endmodule

// File: rtl/rxfd_push.sv
module rxfd_push
  import rxfd_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ERR_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  fc_hit_t           hit,
  input  logic              transparent,
  input  logic [DATA_W-1:0] chr,
  input  logic [ERR_W-1:0]  err,
  output logic              push,
  output logic [DATA_W-1:0] data,
  output logic [ERR_W-1:0]  err_o
);
  logic              push_nxt, push_q;
  logic [DATA_W-1:0] data_q;
  logic [ERR_W-1:0]  err_q;

  always_comb begin
    push_nxt = accept & ~(transparent & (hit.hit_on | hit.hit_off));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      push_q <= 1'b0;
      data_q <= '0;
      err_q  <= '0;
    end else begin
      push_q <= push_nxt;
      if (push_nxt) begin
        data_q <= chr;
        err_q  <= err;
      end
    end
  end

  assign push  = push_q;
  assign data  = data_q;
  assign err_o = err_q;

  assert_transparent_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accept && transparent && (hit.hit_on || hit.hit_off) |=> !push_q);
  assert_plain_push_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !hit.hit_on && !hit.hit_off |=> push_q && (data_q == $past(chr)));
endmodule

// File: rtl/rxfd_gate.sv
module rxfd_gate
  import rxfd_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    sw_reset,
  input  logic    auto_en,
  input  logic    accept,
  input  fc_hit_t hit,
  input  logic    host_stop,
  input  logic    host_resume,
  output logic    tx_en
);
  gate_req_e req;
  logic      en_nxt, en_ld, en_q;

  always_comb begin
    req = GATE_HOLD;
    if (auto_en) begin
      if (accept && hit.hit_off)      req = GATE_STOP;
      else if (accept && hit.hit_on)  req = GATE_RUN;
    end else begin
      if (host_stop)                  req = GATE_STOP;
      else if (host_resume)           req = GATE_RUN;
    end
    if (sw_reset) req = GATE_RUN;
  end

  always_comb begin
    en_ld  = (req != GATE_HOLD);
    en_nxt = (req == GATE_RUN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= 1'b1;
    else if (en_ld) en_q <= en_nxt;
  end

  assign tx_en = en_q;

  assert_swreset_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sw_reset |=> en_q);
  assert_xoff_stops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    auto_en && accept && hit.hit_off && !sw_reset |=> !en_q);
  assert_auto_host_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    auto_en && !accept && !sw_reset |=> $stable(en_q));
  assert_host_rx_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_en && !host_stop && !host_resume && !sw_reset |=> $stable(en_q));
endmodule

// File: rtl/rxfd_status.sv
module rxfd_status
  import rxfd_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    accept,
  input  fc_hit_t hit,
  input  logic    clr,
  input  logic    mask,
  output logic    stat,
  output logic    irq
);
  logic set_evt, stat_nxt, stat_q;

  always_comb begin
    set_evt  = accept & (hit.hit_on | hit.hit_off);
    stat_nxt = set_evt | (stat_q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= 1'b0;
    else        stat_q <= stat_nxt;
  end

  assign stat = stat_q;
  assign irq  = stat_q & mask;

  assert_stat_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q && !clr |=> stat_q);
  assert_stat_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (hit.hit_on || hit.hit_off) |=> stat_q);
  assert_no_spurious_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !accept && !stat_q |=> !stat_q);
endmodule

// File: rtl/rx_flow_detect.sv
module rx_flow_detect
  import rxfd_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ERR_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_char,
  input  logic [ERR_W-1:0]  rx_err,
  input  logic              fifo_full,
  input  logic [DATA_W-1:0] xon_char,
  input  logic [DATA_W-1:0] xoff_char,
  input  logic              auto_gate_en,
  input  logic              transparent,
  input  logic              host_stop,
  input  logic              host_resume,
  input  logic              sw_reset,
  input  logic              irq_mask,
  input  logic              stat_clr,
  output logic              fifo_push,
  output logic [DATA_W-1:0] fifo_data,
  output logic [ERR_W-1:0]  fifo_err,
  output logic              tx_enable,
  output logic              match_stat,
  output logic              irq
);
  logic [1:0] rst_sync;
  logic       rst_n_i;
  logic       accept;
  fc_hit_t    hit;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_i = rst_sync[1];

  // a character is only recognised when the FIFO can take it
  assign accept = rx_valid & ~fifo_full;

  rxfd_match #(.DATA_W(DATA_W)) u_match (
    .chr      (rx_char),
    .xon_ref  (xon_char),
    .xoff_ref (xoff_char),
    .hit      (hit)
  );

  rxfd_push #(.DATA_W(DATA_W), .ERR_W(ERR_W)) u_push (
    .clk         (clk),
    .rst_n       (rst_n_i),
    .accept      (accept),
    .hit         (hit),
    .transparent (transparent),
    .chr         (rx_char),
    .err         (rx_err),
    .push        (fifo_push),
    .data        (fifo_data),
    .err_o       (fifo_err)
  );

  rxfd_gate u_gate (
    .clk         (clk),
    .rst_n       (rst_n_i),
    .sw_reset    (sw_reset),
    .auto_en     (auto_gate_en),
    .accept      (accept),
    .hit         (hit),
    .host_stop   (host_stop),
    .host_resume (host_resume),
    .tx_en       (tx_enable)
  );

  rxfd_status u_status (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .accept (accept),
    .hit    (hit),
    .clr    (stat_clr),
    .mask   (irq_mask),
    .stat   (match_stat),
    .irq    (irq)
  );

  assert_overrun_no_push_R5: assert property (@(posedge clk) disable iff (!rst_n_i)
    rx_valid && fifo_full |=> !fifo_push);
  assert_overrun_gate_R5: assert property (@(posedge clk) disable iff (!rst_n_i)
    fifo_full && !sw_reset && auto_gate_en |=> $stable(tx_enable));
endmodule

// File: tb/test_rx_flow_detect.sv
`timescale 1ns/1ps
module test_rx_flow_detect;
  localparam int DW = 8;
  localparam int EW = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic rx_valid, fifo_full, auto_gate_en, transparent;
  logic host_stop, host_resume, sw_reset, irq_mask, stat_clr;
  logic [DW-1:0] rx_char, xon_char, xoff_char;
  logic [EW-1:0] rx_err;
  logic fifo_push, tx_enable, match_stat, irq;
  logic [DW-1:0] fifo_data;
  logic [EW-1:0] fifo_err;

  int checks = 0;
  int errors = 0;
  logic [DW+EW-1:0] expq[$];

  always #10 clk = ~clk;

  rx_flow_detect #(.DATA_W(DW), .ERR_W(EW)) i_rx_flow_detect (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_char(rx_char),
    .rx_err(rx_err), .fifo_full(fifo_full), .xon_char(xon_char),
    .xoff_char(xoff_char), .auto_gate_en(auto_gate_en),
    .transparent(transparent), .host_stop(host_stop),
    .host_resume(host_resume), .sw_reset(sw_reset), .irq_mask(irq_mask),
    .stat_clr(stat_clr), .fifo_push(fifo_push), .fifo_data(fifo_data),
    .fifo_err(fifo_err), .tx_enable(tx_enable), .match_stat(match_stat),
    .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver: starts on a falling edge, ends on the next one
  task automatic send(input logic [DW-1:0] c, input logic [EW-1:0] e);
    rx_char  = c;
    rx_err   = e;
    rx_valid = 1'b1;
    if (!fifo_full && !(transparent && (c == xon_char || c == xoff_char)))
      expq.push_back({c, e});
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic clr_stat();
    stat_clr = 1'b1;
    @(negedge clk);
    stat_clr = 1'b0;
  endtask

  // monitor: compares each FIFO write with the scoreboard
  always @(negedge clk) begin
    if (rst_n && fifo_push) begin
      if (expq.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2 actual=%0h expected=no write", {fifo_data, fifo_err});
      end else begin
        logic [DW+EW-1:0] e;
        e = expq.pop_front();
        chk("R2 R3 write contents", {fifo_data, fifo_err}, e);
      end
    end
  end

  initial begin
    #(20ns * 200000);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rx_valid = 0; rx_char = '0; rx_err = '0; fifo_full = 0;
    xon_char = 8'h11; xoff_char = 8'h13; auto_gate_en = 1; transparent = 0;
    host_stop = 0; host_resume = 0; sw_reset = 0; irq_mask = 1; stat_clr = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 tx_enable", tx_enable, 1);
    chk("R1 fifo_push", fifo_push, 0);
    chk("R1 match_stat", match_stat, 0);
    chk("R1 irq", irq, 0);

    send(8'h41, 3'b000);
    chk("R2 plain push", fifo_push, 1);
    chk("R11 no status on plain", match_stat, 0);

    send(8'h13, 3'b101);
    chk("R3 errored xoff written", fifo_push, 1);
    chk("R6 xoff stops", tx_enable, 0);
    chk("R10 status set", match_stat, 1);
    chk("R10 irq", irq, 1);
    @(negedge clk);
    chk("R10 status holds", match_stat, 1);
    clr_stat();
    chk("R10 cleared", match_stat, 0);

    host_resume = 1; @(negedge clk); host_resume = 0;
    chk("R8 host resume ignored in auto", tx_enable, 0);

    send(8'h11, 3'b000);
    chk("R6 xon restarts", tx_enable, 1);
    // clear and new match in the same cycle: match wins
    stat_clr = 1'b1;
    send(8'h41, 3'b000);
    stat_clr = 1'b0;
    chk("R10 clear lands", match_stat, 0);
    stat_clr = 1'b1;
    send(8'h11, 3'b000);
    stat_clr = 1'b0;
    chk("R10 set beats clear", match_stat, 1);
    clr_stat();

    transparent = 1;
    send(8'h13, 3'b010);
    chk("R4 matched not written", fifo_push, 0);
    chk("R6 xoff stops (transparent)", tx_enable, 0);
    send(8'h55, 3'b000);
    chk("R4 plain still written", fifo_push, 1);
    clr_stat();

    fifo_full = 1;
    send(8'h11, 3'b000);
    chk("R5 no write on overrun", fifo_push, 0);
    chk("R5 gate unchanged", tx_enable, 0);
    chk("R5 status unchanged", match_stat, 0);
    fifo_full = 0;

    sw_reset = 1; @(negedge clk); sw_reset = 0;
    chk("R9 sw reset releases", tx_enable, 1);
    send(8'h13, 3'b000);
    chk("R6 stop again", tx_enable, 0);
    sw_reset = 1;
    send(8'h13, 3'b000);
    sw_reset = 0;
    chk("R9 sw reset beats xoff", tx_enable, 1);
    clr_stat();

    auto_gate_en = 0; transparent = 0;
    send(8'h13, 3'b000);
    chk("R8 xoff ignored in host mode", tx_enable, 1);
    chk("R10 status in host mode", match_stat, 1);
    irq_mask = 0; @(negedge clk);
    chk("R10 masked irq", irq, 0);
    irq_mask = 1;
    clr_stat();
    host_stop = 1; @(negedge clk); host_stop = 0;
    chk("R8 host stop", tx_enable, 0);
    chk("R11 no status from command", match_stat, 0);
    send(8'h11, 3'b000);
    chk("R8 xon ignored in host mode", tx_enable, 0);
    host_resume = 1; @(negedge clk); host_resume = 0;
    chk("R8 host resume", tx_enable, 1);
    host_stop = 1; host_resume = 1; @(negedge clk); host_stop = 0; host_resume = 0;
    chk("R8 stop wins", tx_enable, 0);
    host_resume = 1; @(negedge clk); host_resume = 0;
    clr_stat();

    auto_gate_en = 1; xoff_char = 8'h00;
    send(8'h00, 3'b100);
    chk("R7 break zero stops", tx_enable, 0);
    chk("R7 break zero written", fifo_push, 1);
    sw_reset = 1; @(negedge clk); sw_reset = 0;

    xon_char = 8'h22; xoff_char = 8'h22;
    send(8'h22, 3'b000);
    chk("R6 stop wins on equal refs", tx_enable, 0);

    repeat (3) @(negedge clk);
    chk("R2 scoreboard drained", expq.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule